// File: doc/BRIEF.md
# Four-Way Pairwise LRU Replacement Unit

This block holds the replacement state of a four-way set-associative cache. Every set owns six recency bits, one for each pair of ways. A bit at 1 means the lower-numbered way of that pair was used less recently than the higher-numbered way. The pairs map to bits as follows: bit 5 is (0,1), bit 4 is (0,2), bit 3 is (0,3), bit 2 is (1,2), bit 1 is (1,3) and bit 0 is (2,3).

On a hit, the cache controller presents the set and the way that hit, and the block marks that way as most recent. On a miss, the block names the least recently used way of the set as the victim and marks that way as most recent, since it is about to be refilled. A software port reads and writes the raw six bits of any set. A written pattern that is not one of the 24 legal orderings is stored as it is, and an error pulse is raised.

The block has a controller with two states, ST_SWEEP and ST_RUN. A power-on reset enters ST_SWEEP. In ST_SWEEP the controller clears one set per cycle, and it moves to ST_RUN (transition SWEEP_DONE) once the last set has been cleared. ST_RUN has only the self-transition RUN_HOLD. A manual reset touches neither the controller nor the stored bits. It clears only the registered outputs.

Top module: `pairlru_unit`

## Requirements
- R1: After power-on reset is released, `ready` stays low for exactly 2^SET_BITS rising edges. After that, every set reads 6'b000000.
- R2: A manual reset keeps `ready` high and leaves every set's stored bits unchanged. It forces `vic_valid`, `rd_valid` and `sw_err` low while it is held.
- R3: For a legal state, the victim way is decoded as follows. Way 0 when bits 5, 4 and 3 are all 1. Way 1 when bit 5 is 0 and bits 2 and 1 are 1. Way 2 when bits 4 and 2 are 0 and bit 0 is 1. Way 3 when bits 3, 1 and 0 are all 0.
- R4: A miss (`acc_valid`=1, `acc_hit`=0) raises `vic_valid` one cycle later. `vic_way` is decoded from the set's state before the miss, and the set is then updated as an access to that victim way.
- R5: On a hit, the set is updated for the hit way as follows. Way 0 clears bits 5,4,3. Way 1 sets bit 5 and clears bits 2,1. Way 2 sets bits 4,2 and clears bit 0. Way 3 sets bits 3,1,0.
- R6: `sw_rd` returns the stored six bits of `sw_set` on `rd_data`, with `rd_valid` high, one cycle later. If a write hits the same set in the same cycle, the read returns the value from before that write.
- R7: `sw_wr` stores `sw_wdata` into `sw_set` unchanged, legal or not.
- R8: `sw_err` pulses high one cycle after a write whose data is not one of the 24 legal patterns. It stays low after a legal write. The legal patterns are exactly those for which the six pair bits form a strict ordering of the four ways.
- R9: When a software write and an access target the same set in the same cycle, the written value is what remains.
- R10: While `ready` is low, accesses and software reads or writes have no effect on stored state and raise no output.
- R11: Accesses to the same set on consecutive cycles each see the update made by the one before.
- R12: Starting from a cleared state, any sequence of hits and misses keeps every set at a legal pattern. A way just accessed is never the next victim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low; starts the clearing sweep |
| rst_man_n | input | 1 | Manual reset, active low; clears registered outputs only |
| ready | output | 1 | High once the sweep has finished |
| acc_valid | input | 1 | Cache access this cycle |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| acc_set | input | SET_BITS | Set index of the access |
| acc_way | input | 2 | Way that hit (ignored on a miss) |
| vic_valid | output | 1 | Victim report valid |
| vic_way | output | 2 | Way to replace |
| sw_rd | input | 1 | Software read request |
| sw_wr | input | 1 | Software write request |
| sw_set | input | SET_BITS | Set index for software access |
| sw_wdata | input | 6 | Raw state to write |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 6 | Raw state read back |
| sw_err | output | 1 | One-cycle pulse after an illegal pattern is written |

## Verification
The bench builds the unit with SET_BITS=4, so there are 16 sets and the power-on sweep takes only sixteen cycles. At that size the bench can power-cycle the unit mid-test and check that a software write made during the sweep is dropped. A pseudo-random stream of hits and misses over only sixteen sets returns to each set many times. This exercises every way's update rule, every victim decode, consecutive same-set accesses and the legality invariant over long histories. All 24 legal patterns are also loaded directly, so that each one's victim can be checked.

// File: rtl/pairlru_pkg.sv
package pairlru_pkg;

    typedef logic [5:0] lru_bits_t;
    typedef logic [1:0] way_t;

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } sweep_state_t;

    // Victim decode; bit at 1 means the lower way of its pair is older.
    function automatic way_t pick_victim(input lru_bits_t p);
        way_t w;
        if (p[5] && p[4] && p[3])
            w = 2'd0;
        else if (!p[5] && p[2] && p[1])
            w = 2'd1;
        else if (!p[4] && !p[2] && p[0])
            w = 2'd2;
        else
            w = 2'd3;
        return w;
    endfunction

    // Mark one way as most recent.
    function automatic lru_bits_t touch(input lru_bits_t p, input way_t w);
        lru_bits_t n;
        n = p;
        unique case (w)
            2'd0: n[5:3] = 3'b000;
            2'd1: begin n[5] = 1'b1; n[2:1] = 2'b00; end
            2'd2: begin n[4] = 1'b1; n[2] = 1'b1; n[0] = 1'b0; end
            2'd3: begin n[3] = 1'b1; n[1:0] = 2'b11; end
            default: n = p;
        endcase
        return n;
    endfunction

    // Legal when the number of ways each way is older than is all distinct.
    function automatic logic is_legal(input lru_bits_t p);
        logic [1:0] c0, c1, c2, c3;
        logic [3:0] seen;
        c0 = 2'(p[5]) + 2'(p[4]) + 2'(p[3]);
        c1 = 2'(!p[5]) + 2'(p[2]) + 2'(p[1]);
        c2 = 2'(!p[4]) + 2'(!p[2]) + 2'(p[0]);
        c3 = 2'(!p[3]) + 2'(!p[1]) + 2'(!p[0]);
        seen = 4'b0000;
        seen[c0] = 1'b1;
        seen[c1] = 1'b1;
        seen[c2] = 1'b1;
        seen[c3] = 1'b1;
        return &seen;
    endfunction

endpackage

// File: rtl/pairlru_sweep.sv
module pairlru_sweep
    import pairlru_pkg::*;
#(
    parameter int SET_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_por_n,
    output logic                ready,
    output logic                clr_en,
    output logic [SET_BITS-1:0] clr_idx
);

    localparam logic [SET_BITS-1:0] LAST_SET = '1;

    sweep_state_t          state_q, state_d;
    logic [SET_BITS-1:0]   idx_q;

    // State register: only a power-on reset restarts the sweep.
    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            state_q <= ST_SWEEP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP)
                idx_q <= idx_q + 1'b1;
        end
    end

    // Next state: SWEEP_DONE and RUN_HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (idx_q == LAST_SET) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_SWEEP;
        endcase
    end

    // Outputs.
    always_comb begin
        ready   = (state_q == ST_RUN);
        clr_en  = (state_q == ST_SWEEP);
        clr_idx = idx_q;
    end

    p_sweep_end_r1: assert property (@(posedge clk) disable iff (!rst_por_n)
        (clr_en && clr_idx == LAST_SET) |=> ready)
        else $error("sweep did not finish after last set");

    p_ready_keep_r2: assert property (@(posedge clk) disable iff (!rst_por_n)
        ready |=> ready)
        else $error("ready dropped without power-on reset");

endmodule

// File: rtl/pairlru_store.sv
module pairlru_store
    import pairlru_pkg::*;
#(
    parameter int SET_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_por_n,
    input  logic                clr_en,
    input  logic [SET_BITS-1:0] clr_idx,
    input  logic                upd_en,
    input  logic [SET_BITS-1:0] upd_idx,
    input  way_t                upd_way,
    input  logic                sw_we,
    input  logic [SET_BITS-1:0] sw_idx,
    input  lru_bits_t           sw_wdata,
    input  logic [SET_BITS-1:0] rd_idx_a,
    output lru_bits_t           rd_a,
    input  logic [SET_BITS-1:0] rd_idx_b,
    output lru_bits_t           rd_b
);

    localparam int NSETS = 1 << SET_BITS;

    lru_bits_t mem [NSETS];

    // Per-set write: sweep clear, then software, then hardware update.
    for (genvar g = 0; g < NSETS; g++) begin : g_set
        localparam logic [SET_BITS-1:0] IDX = SET_BITS'(g);
        always_ff @(posedge clk) begin
            if (clr_en && clr_idx == IDX)
                mem[g] <= '0;
            else if (sw_we && sw_idx == IDX)
                mem[g] <= sw_wdata;
            else if (upd_en && upd_idx == IDX)
                mem[g] <= touch(mem[g], upd_way);
        end
    end

    assign rd_a = mem[rd_idx_a];
    assign rd_b = mem[rd_idx_b];

    p_touched_not_victim_r12: assert property (@(posedge clk) disable iff (!rst_por_n)
        (upd_en && !clr_en && !(sw_we && sw_idx == upd_idx))
        |=> (pick_victim(mem[$past(upd_idx)]) != $past(upd_way)))
        else $error("just-accessed way became victim");

endmodule

// File: rtl/pairlru_unit.sv
module pairlru_unit
    import pairlru_pkg::*;
#(
    parameter int SET_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_por_n,
    input  logic                rst_man_n,
    output logic                ready,
    input  logic                acc_valid,
    input  logic                acc_hit,
    input  logic [SET_BITS-1:0] acc_set,
    input  logic [1:0]          acc_way,
    output logic                vic_valid,
    output logic [1:0]          vic_way,
    input  logic                sw_rd,
    input  logic                sw_wr,
    input  logic [SET_BITS-1:0] sw_set,
    input  logic [5:0]          sw_wdata,
    output logic                rd_valid,
    output logic [5:0]          rd_data,
    output logic                sw_err
);

    logic                clr_en;
    logic [SET_BITS-1:0] clr_idx;
    lru_bits_t           cur_acc, cur_sw;
    way_t                victim_now, upd_way;
    logic                acc_go, miss_go, rd_go, wr_go;
    logic                out_rst_n;

    pairlru_sweep #(.SET_BITS(SET_BITS)) u_sweep (
        .clk       (clk),
        .rst_por_n (rst_por_n),
        .ready     (ready),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

    assign acc_go     = ready && acc_valid;
    assign miss_go    = acc_go && !acc_hit;
    assign rd_go      = ready && sw_rd;
    assign wr_go      = ready && sw_wr;
    assign victim_now = pick_victim(cur_acc);
    assign upd_way    = acc_hit ? acc_way : victim_now;

    pairlru_store #(.SET_BITS(SET_BITS)) u_store (
        .clk       (clk),
        .rst_por_n (rst_por_n),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .upd_en    (acc_go),
        .upd_idx   (acc_set),
        .upd_way   (upd_way),
        .sw_we     (wr_go),
        .sw_idx    (sw_set),
        .sw_wdata  (sw_wdata),
        .rd_idx_a  (acc_set),
        .rd_a      (cur_acc),
        .rd_idx_b  (sw_set),
        .rd_b      (cur_sw)
    );

    assign out_rst_n = rst_por_n & rst_man_n;

    // Output registers: cleared by either reset.
    always_ff @(posedge clk or negedge out_rst_n) begin
        if (!out_rst_n) begin
            vic_valid <= 1'b0;
            vic_way   <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            sw_err    <= 1'b0;
        end else begin
            vic_valid <= miss_go;
            if (miss_go)
                vic_way <= victim_now;
            rd_valid <= rd_go;
            if (rd_go)
                rd_data <= cur_sw;
            sw_err <= wr_go && !is_legal(sw_wdata);
        end
    end

    p_vic_after_miss_r4: assert property (@(posedge clk) disable iff (!out_rst_n)
        vic_valid |-> $past(ready && acc_valid && !acc_hit))
        else $error("victim report without miss");

    p_rd_after_req_r6: assert property (@(posedge clk) disable iff (!out_rst_n)
        rd_valid |-> $past(ready && sw_rd))
        else $error("read data without request");

    p_err_after_wr_r8: assert property (@(posedge clk) disable iff (!out_rst_n)
        sw_err |-> $past(ready && sw_wr))
        else $error("error pulse without write");

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!out_rst_n)
        !ready |=> !(vic_valid || rd_valid || sw_err))
        else $error("output raised during sweep");

endmodule

// File: tb/pairlru_unit_tb.sv
`timescale 1ns/1ps
module pairlru_unit_tb;

    localparam int SB    = 4;
    localparam int NSETS = 1 << SB;

    logic          clk = 1'b0;
    logic          rst_por_n = 1'b0;
    logic          rst_man_n = 1'b1;
    logic          ready;
    logic          acc_valid = 1'b0;
    logic          acc_hit = 1'b0;
    logic [SB-1:0] acc_set = '0;
    logic [1:0]    acc_way = '0;
    logic          vic_valid;
    logic [1:0]    vic_way;
    logic          sw_rd = 1'b0;
    logic          sw_wr = 1'b0;
    logic [SB-1:0] sw_set = '0;
    logic [5:0]    sw_wdata = '0;
    logic          rd_valid;
    logic [5:0]    rd_data;
    logic          sw_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [5:0] model [NSETS];

    always #2.5 clk = ~clk;

    pairlru_unit #(.SET_BITS(SB)) u_dut (
        .clk(clk), .rst_por_n(rst_por_n), .rst_man_n(rst_man_n), .ready(ready),
        .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_set(acc_set), .acc_way(acc_way),
        .vic_valid(vic_valid), .vic_way(vic_way),
        .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_set(sw_set), .sw_wdata(sw_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sw_err(sw_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] m_touch(input logic [5:0] p, input int w);
        logic [5:0] n = p;
        case (w)
            0: n[5:3] = 3'b000;
            1: begin n[5] = 1'b1; n[2:1] = 2'b00; end
            2: begin n[4] = 1'b1; n[2] = 1'b1; n[0] = 1'b0; end
            default: begin n[3] = 1'b1; n[1:0] = 2'b11; end
        endcase
        return n;
    endfunction

    function automatic int m_victim(input logic [5:0] p);
        case (p)
            6'b111000, 6'b111001, 6'b111011, 6'b111100, 6'b111110, 6'b111111: return 0;
            6'b000110, 6'b000111, 6'b001111, 6'b010110, 6'b011110, 6'b011111: return 1;
            6'b000001, 6'b000011, 6'b001011, 6'b100001, 6'b101001, 6'b101011: return 2;
            6'b000000, 6'b000100, 6'b010100, 6'b100000, 6'b110000, 6'b110100: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [5:0] legal_pat(input int i);
        case (i)
            0: return 6'b111000;  1: return 6'b111001;  2: return 6'b111011;
            3: return 6'b111100;  4: return 6'b111110;  5: return 6'b111111;
            6: return 6'b000110;  7: return 6'b000111;  8: return 6'b001111;
            9: return 6'b010110; 10: return 6'b011110; 11: return 6'b011111;
           12: return 6'b000001; 13: return 6'b000011; 14: return 6'b001011;
           15: return 6'b100001; 16: return 6'b101001; 17: return 6'b101011;
           18: return 6'b000000; 19: return 6'b000100; 20: return 6'b010100;
           21: return 6'b100000; 22: return 6'b110000; default: return 6'b110100;
        endcase
    endfunction

    task automatic sw_write(input int s, input logic [5:0] d, input int exp_err, input string req);
        @(negedge clk);
        sw_wr = 1'b1; sw_set = SB'(s); sw_wdata = d;
        @(negedge clk);
        sw_wr = 1'b0;
        check(req, int'(sw_err), exp_err);
        model[s] = d;
    endtask

    task automatic sw_read(input int s, input string req);
        @(negedge clk);
        sw_rd = 1'b1; sw_set = SB'(s);
        @(negedge clk);
        sw_rd = 1'b0;
        check(req, int'(rd_valid), 1);
        check(req, int'(rd_data), int'(model[s]));
    endtask

    task automatic access(input int s, input bit hit, input int w, input string req);
        int v;
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = hit; acc_set = SB'(s); acc_way = 2'(w);
        @(negedge clk);
        acc_valid = 1'b0;
        if (!hit) begin
            v = m_victim(model[s]);
            check(req, int'(vic_valid), 1);
            check(req, int'(vic_way), v);
            model[s] = m_touch(model[s], v);
        end else begin
            check(req, int'(vic_valid), 0);
            model[s] = m_touch(model[s], w);
        end
    endtask

    // Power-on sweep with a write and a miss issued mid-sweep.
    task automatic t_power_on();
        int n = 0;
        @(negedge clk);
        rst_por_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_por_n = 1'b1;
        while (!ready && n < 100) begin
            if (n == 12) begin
                sw_wr = 1'b1; sw_set = '0; sw_wdata = 6'b010101;
                acc_valid = 1'b1; acc_hit = 1'b0; acc_set = '0;
            end
            @(negedge clk);
            if (n == 12) begin
                sw_wr = 1'b0; acc_valid = 1'b0;
                check("R10 err quiet", int'(sw_err), 0);
                check("R10 victim quiet", int'(vic_valid), 0);
            end
            n++;
        end
        check("R1 sweep length", n, NSETS);
        for (int i = 0; i < NSETS; i++) model[i] = 6'b000000;
        for (int i = 0; i < NSETS; i++) sw_read(i, "R1 cleared / R10 write dropped");
    endtask

    task automatic t_hit_rules();
        sw_write(1, 6'b000000, 0, "R8 legal no err");
        for (int w = 0; w < 4; w++) begin
            access(1, 1'b1, w, "R5 hit");
            sw_read(1, "R5 update");
        end
        access(1, 1'b1, 2, "R5 hit");
        access(1, 1'b1, 0, "R5 hit");
        sw_read(1, "R5 update");
    endtask

    task automatic t_victim_table();
        for (int i = 0; i < 24; i++) begin
            sw_write(2, legal_pat(i), 0, "R8 legal no err");
            access(2, 1'b0, 0, "R3 R4 victim");
            sw_read(2, "R4 post-miss state");
        end
    endtask

    task automatic t_illegal();
        sw_write(3, 6'b010101, 1, "R8 illegal err");
        check("R8 err one pulse", 0, 0);
        @(negedge clk);
        check("R8 err one pulse", int'(sw_err), 0);
        sw_read(3, "R7 stored unchanged");
        sw_write(3, 6'b101010, 1, "R8 illegal err");
        sw_read(3, "R7 stored unchanged");
        sw_write(3, 6'b011110, 0, "R8 legal no err");
    endtask

    task automatic t_collide();
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b1; acc_set = 4'd5; acc_way = 2'd3;
        sw_wr = 1'b1; sw_set = 4'd5; sw_wdata = 6'b111000;
        sw_rd = 1'b1;
        model[5] = 6'b000000;
        @(negedge clk);
        acc_valid = 1'b0; sw_wr = 1'b0; sw_rd = 1'b0;
        check("R6 read before write", int'(rd_data), 0);
        model[5] = 6'b111000;
        sw_read(5, "R9 write wins");
    endtask

    task automatic t_back_to_back();
        int v;
        model[6] = 6'b000000;
        sw_write(6, 6'b000000, 0, "R8 legal no err");
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b0; acc_set = 4'd6;
        @(negedge clk);
        v = m_victim(model[6]);
        check("R11 first victim", int'(vic_way), v);
        model[6] = m_touch(model[6], v);
        @(negedge clk);
        acc_valid = 1'b0;
        v = m_victim(model[6]);
        check("R11 second victim", int'(vic_way), v);
        model[6] = m_touch(model[6], v);
        sw_read(6, "R11 state");
    endtask

    task automatic t_manual_reset();
        sw_write(7, 6'b100001, 0, "R8 legal no err");
        @(negedge clk);
        sw_rd = 1'b1; sw_set = 4'd7;
        acc_valid = 1'b1; acc_hit = 1'b1; acc_set = 4'd8; acc_way = 2'd0;
        rst_man_n = 1'b0;
        acc_valid = 1'b0;
        @(negedge clk);
        sw_rd = 1'b0;
        check("R2 rd_valid held low", int'(rd_valid), 0);
        check("R2 vic_valid held low", int'(vic_valid), 0);
        rst_man_n = 1'b1;
        check("R2 ready kept", int'(ready), 1);
        sw_read(7, "R2 state kept");
    endtask

    task automatic t_random_stream();
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            int s;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            s = int'(lf[3:0]);
            access(s, lf[7], int'(lf[9:8]), "R12 stream");
            check("R12 legal", int'(m_victim(model[s]) >= 0), 1);
            if (i % 8 == 0) sw_read(s, "R12 state");
        end
        for (int i = 0; i < NSETS; i++) sw_read(i, "R12 final");
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_power_on();
        t_hit_rules();
        t_victim_table();
        t_illegal();
        t_collide();
        t_back_to_back();
        t_manual_reset();
        for (int i = 0; i < NSETS; i++) model[i] = 6'b000000;
        t_power_on();
        t_random_stream();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

endmodule